// File: doc/BRIEF.md
# Prioritized Interrupt Aggregator

This block gathers interrupt events from up to 32 source positions and presents them to a processor as a single request line plus the number of the most urgent enabled source. Six positions take asynchronous external pins. Each pin passes through a two-flop synchronizer, and a rising edge on the pin records an event. Eight positions take single-cycle event strobes from on-chip peripherals: a serial port, a DMA engine and a JTAG controller. The remaining positions are not connected. Their status bits stay at zero.

Each position has a latched status bit and an enable bit. A source counts as pending only when both bits are set. Software reads and writes both words through a small register port. Writing enable bits changes which sources are pending but never changes the status bits. Software acknowledges a source by writing a 1 to its status bit. Bits are numbered big-endian: source n lives at register bit 31−n. Source 0 has the highest priority. The vector and request outputs are registered. They follow any change in status or enable one clock later.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the status word and the enable word both read 0, `irq_o` is 0, `irq_none_o` is 1 and `irq_vec_o` is 0.
- R2: External pin k (k = 0..5) is source k. A rising edge on the pin, seen after the two-flop synchronizer, sets that source's status bit. A pin held high sets the bit once only, so after the bit is cleared it stays clear until the pin falls and rises again.
- R3: Internal strobe j (j = 0..7) is source 6+j. When the strobe is high at a clock edge, that source's status bit is set.
- R4: Register bit (31−n) holds source n. `bus_addr_i` = 0 selects the status word and 1 selects the enable word. `bus_rdata_o` shows the selected word combinationally.
- R5: A status write clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R6: If a source event and a clearing write hit the same status bit in the same cycle, the bit ends up set. Other bits cleared by that write still clear.
- R7: The enable word is fully readable and writable as 32 bits. Writing it never changes the status word.
- R8: `irq_o` is the OR of (status AND enable), registered, so it reflects a change one cycle after the status or enable word changes.
- R9: While any source is pending, `irq_none_o` is 0 and `irq_vec_o` is the lowest-numbered pending source, with the same one-cycle latency.
- R10: With nothing pending, `irq_none_o` is 1 and `irq_vec_o` is 0.
- R11: Source positions 14 to 31 have no input. Their status bits always read 0, but their enable bits still store what is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 6 | Asynchronous external interrupt pins |
| int_evt_i | input | 8 | Synchronous internal event strobes |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high together with `bus_sel_i` |
| bus_addr_i | input | 1 | 0 = status word, 1 = enable word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected word |
| irq_o | output | 1 | Processor interrupt request |
| irq_vec_o | output | 5 | Number of the highest-priority pending source |
| irq_none_o | output | 1 | High when no enabled source is pending |

## Verification
Two functions can land on the same status bit in one cycle: a peripheral event setting the bit and a software acknowledge clearing it. The bench raises an internal strobe on the same negative edge that it drives a clearing write. That write covers the strobed source and a second, already-set source. After the edge, the strobed bit must read 1 and the other bit must read 0. The bench also checks that the vector outputs keep their old values in the cycle directly after an enable write and change one cycle later.

// File: rtl/aic_pkg.sv
package aic_pkg;
  localparam int SRC_N = 32;
  localparam int VEC_W = $clog2(SRC_N);

  typedef logic [SRC_N-1:0] src_vec_t;

  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_ENABLE = 1'b1
  } reg_sel_e;

  // register bit (SRC_N-1-n) <-> source n
  function automatic src_vec_t flip_order(input src_vec_t w);
    src_vec_t r;
    for (int i = 0; i < SRC_N; i++) r[i] = w[SRC_N-1-i];
    return r;
  endfunction

  function automatic src_vec_t wired_mask(input int ext_base, input int n_ext,
                                          input int int_base, input int n_int);
    src_vec_t m;
    m = '0;
    for (int i = 0; i < n_ext; i++) m[ext_base+i] = 1'b1;
    for (int i = 0; i < n_int; i++) m[int_base+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/aic_edge_sync.sv
module aic_edge_sync #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic meta_q, sync_q, last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end
    assign rise_o[g] = sync_q & ~last_q;

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/aic_src_regs.sv
module aic_src_regs
  import aic_pkg::*;
#(
  parameter src_vec_t WIRED = '1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_i,
  input  logic     wr_stat_i,
  input  logic     wr_en_i,
  input  src_vec_t wdata_i,
  output src_vec_t status_o,
  output src_vec_t enable_o
);
  src_vec_t status_q, enable_q, clr_vec, status_d;

  always_comb begin
    clr_vec  = wr_stat_i ? wdata_i : '0;
    // set applied after clear: an event is never lost
    status_d = (status_q & ~clr_vec) | (set_i & WIRED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      if (wr_en_i) enable_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat_i && set_i == '0) |=> ((status_o & $past(wdata_i)) == '0));
  // R7
  status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat_i && set_i == '0) |=> $stable(status_o));
  // R7
  enable_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (enable_o == $past(wdata_i)));
endmodule

// File: rtl/aic_prio_enc.sv
module aic_prio_enc
  import aic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         pend_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             none_o
);
  logic [VEC_W-1:0] sel;
  logic             found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = SRC_N-1; i >= 0; i--) begin
      if (pend_i[i]) begin
        sel   = VEC_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_o  <= '0;
      none_o <= 1'b1;
    end else begin
      vec_o  <= sel;
      none_o <= ~found;
    end
  end

  src_vec_t pend_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_prev <= '0;
    else        pend_prev <= pend_i;
  end

  // R10
  none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |=> (none_o && vec_o == '0));
  // R9
  lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !none_o |-> (pend_prev[vec_o] &&
                 ((pend_prev & ((src_vec_t'(1) << vec_o) - src_vec_t'(1))) == '0)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import aic_pkg::*;
#(
  parameter int NUM_EXT  = 6,
  parameter int NUM_INT  = 8,
  parameter int EXT_BASE = 0,
  parameter int INT_BASE = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic [NUM_INT-1:0] int_evt_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic               bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o,
  output logic [4:0]         irq_vec_o,
  output logic               irq_none_o
);
  localparam src_vec_t WIRED = wired_mask(EXT_BASE, NUM_EXT, INT_BASE, NUM_INT);

  logic [NUM_EXT-1:0] ext_rise;
  src_vec_t set_vec, status, enable, pending, wdata_src;
  logic wr_stat, wr_en, irq_q;

  aic_edge_sync #(.N(NUM_EXT)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_irq_i), .rise_o(ext_rise)
  );

  always_comb begin
    set_vec = '0;
    for (int e = 0; e < NUM_EXT; e++) set_vec[EXT_BASE+e] = ext_rise[e];
    for (int j = 0; j < NUM_INT; j++) set_vec[INT_BASE+j] = int_evt_i[j];
  end

  assign wdata_src = flip_order(bus_wdata_i);
  assign wr_stat   = bus_sel_i && bus_we_i && (reg_sel_e'(bus_addr_i) == REG_STATUS);
  assign wr_en     = bus_sel_i && bus_we_i && (reg_sel_e'(bus_addr_i) == REG_ENABLE);

  aic_src_regs #(.WIRED(WIRED)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .wr_stat_i(wr_stat),
    .wr_en_i(wr_en), .wdata_i(wdata_src), .status_o(status), .enable_o(enable)
  );

  assign bus_rdata_o = (reg_sel_e'(bus_addr_i) == REG_ENABLE) ? flip_order(enable)
                                                               : flip_order(status);
  assign pending = status & enable;

  aic_prio_enc u_enc (
    .clk(clk), .rst_n(rst_n), .pend_i(pending), .vec_o(irq_vec_o), .none_o(irq_none_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pending;
  end
  assign irq_o = irq_q;

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pending) |=> irq_o);
  // R8
  irq_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !irq_none_o);
  // R11
  unwired_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~WIRED) == '0);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] ext_irq = '0;
  logic [7:0] int_evt = '0;
  logic bus_sel = 0, bus_we = 0, bus_addr = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, irq_none;
  logic [4:0] irq_vec;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .int_evt_i(int_evt),
    .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq),
    .irq_vec_o(irq_vec), .irq_none_o(irq_none)
  );

  function automatic logic [31:0] rb(input int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic vec_chk(input string req, input int v);
    chk(req, {31'b0, irq_none}, (v < 0) ? 32'd1 : 32'd0);
    chk(req, {31'b0, irq}, (v < 0) ? 32'd0 : 32'd1);
    chk(req, {27'b0, irq_vec}, (v < 0) ? 32'd0 : 32'(v));
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    rd(0, d); chk("R1 status", d, 0);
    rd(1, d); chk("R1 enable", d, 0);
    vec_chk("R1 outputs", -1);

    // R7 R11 enable sweep, every bit incl. unwired
    for (int n = 0; n < 32; n++) begin
      wr(1, rb(n)); rd(1, d); chk("R7 R11 enable onehot", d, rb(n));
    end
    wr(1, 32'hA5C3_0F96); rd(1, d); chk("R7 enable pattern", d, 32'hA5C3_0F96);
    rd(0, d); chk("R7 status untouched", d, 0);
    wr(1, 0);

    // R3 R4 internal strobes
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); int_evt[j] = 1;
      @(negedge clk); int_evt[j] = 0;
      rd(0, d); chk("R3 R4 internal bit", d, rb(6 + j));
      wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R5 clear all", d, 0);
    end

    // R2 R4 external pins
    for (int e = 0; e < 6; e++) begin
      @(negedge clk); ext_irq[e] = 1;
      tick(2);
      rd(0, d); chk("R2 not yet through sync", d, 0);
      tick(1);
      rd(0, d); chk("R2 R4 external bit", d, rb(e));
      tick(5);
      wr(0, rb(e));
      tick(4);
      rd(0, d); chk("R2 held high no re-set", d, 0);
      ext_irq[e] = 0;
      tick(4);
    end
    // R2 re-arm after fall
    @(negedge clk); ext_irq[2] = 1; tick(3);
    rd(0, d); chk("R2 re-arm", d, rb(2));
    ext_irq[2] = 0; wr(0, 32'hFFFF_FFFF); tick(4);

    // R11 fire everything
    @(negedge clk); ext_irq = 6'h3F; int_evt = 8'hFF;
    @(negedge clk); int_evt = 0;
    tick(3);
    ext_irq = 0;
    rd(0, d); chk("R11 only wired set", d, 32'hFFFC_0000);
    vec_chk("R10 masked nothing pending", -1);

    // R8 R9 mask sweep
    for (int m = 0; m < 14; m++) begin
      wr(1, rb(m) | rb(13));
      tick(1);
      vec_chk("R8 R9 mask pair", m);
    end
    wr(1, 0);
    vec_chk("R8 one-cycle latency old value", 13);
    tick(1);
    vec_chk("R10 enable cleared", -1);
    rd(0, d); chk("R7 mask change keeps status", d, 32'hFFFC_0000);

    // R9 priority drain
    wr(1, 32'hFFFF_FFFF);
    tick(1);
    for (int k = 0; k < 14; k++) begin
      vec_chk("R9 drain", k);
      wr(0, rb(k));
      tick(1);
    end
    vec_chk("R10 drained", -1);

    // R5 zero write no effect, partial clear
    @(negedge clk); ext_irq = 6'h3F; int_evt = 8'hFF;
    @(negedge clk); int_evt = 0;
    tick(3); ext_irq = 0; tick(3);
    wr(0, 0); rd(0, d); chk("R5 zero write", d, 32'hFFFC_0000);
    wr(0, 32'h5555_0000); rd(0, d); chk("R5 partial", d, 32'hAAA8_0000);

    // R6 set vs clear same cycle: source 6 (strobe 0) and source 7 set
    wr(0, 32'hFFFF_FFFF);
    @(negedge clk); int_evt[1] = 1;
    @(negedge clk); int_evt[1] = 0;
    rd(0, d); chk("R6 prep", d, rb(7));
    @(negedge clk);
    int_evt[0] = 1;
    bus_sel = 1; bus_we = 1; bus_addr = 0; bus_wdata = rb(6) | rb(7);
    @(negedge clk);
    int_evt[0] = 0; bus_sel = 0; bus_we = 0;
    rd(0, d); chk("R6 set wins, other cleared", d, rb(6));
    tick(1);
    vec_chk("R6 R9 vector", 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule